// File: doc/BRIEF.md
# Control-Register Bus Slave

This block is the peripheral end of a simple control-register bus. A requester running from a clock at half the peripheral clock rate presents a 10-bit register address, a 32-bit write word and one of two request strobes, one for reads and one for writes. The slave holds a small bank of 32-bit registers mapped at a configurable base address. It answers each accepted access with a registered acknowledge, which travels alongside the returned read word.

All request inputs pass through a chain of synchronising flip-flops in the peripheral clock domain before any decision is taken. The acknowledge follows a four-phase handshake. It rises once the access is done and stays high until the requester drops the strobe that started the access. The slave then returns to idle. A write lands in the register bank exactly once per handshake, however long the strobe stays high. Addresses outside the slave's window get no acknowledge. Asserting both strobes together is treated as a protocol error and gets no response.

Top module: `ctrl_reg_slave`

## Requirements
- R1: A synchronous active-low reset clears every register of the bank, the acknowledge and the read-data output to zero.
- R2: Request strobes, address and write data pass through two synchronising flip-flop stages. For an in-window single-strobe request, the acknowledge is still low after the second rising edge following the change at the inputs and high after the third.
- R3: An address hits when it lies in the range BASE_ADDR to BASE_ADDR+NUM_REGS-1 (default 0x100 to 0x103). The register selected is the address minus BASE_ADDR.
- R4: A write stores the synchronised write word into the selected register once, in the cycle it is accepted. Changes to the write data while the strobe stays high do not alter the register.
- R5: For a read, the read-data output equals the selected register when the acknowledge rises and stays unchanged while the acknowledge stays high. Whenever the acknowledge is low, read data is zero.
- R6: The acknowledge stays high for as long as the strobe that started the access stays high. It falls on the third rising edge after that strobe drops.
- R7: A request to an address outside the window never raises the acknowledge, writes no register and leaves read data at zero.
- R8: While both strobes are high together, the slave raises no acknowledge and writes no register.
- R9: A new request is accepted only from idle. Address or data changes during an acknowledged access leave the read data and the register bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_rd | input | 1 | Read request strobe from the requester |
| req_wr | input | 1 | Write request strobe from the requester |
| req_addr | input | 10 | Register address |
| req_wdata | input | 32 | Write data word |
| rsp_ack | output | 1 | Registered acknowledge, four-phase |
| rsp_rdata | output | 32 | Read data returned with the acknowledge |

## Verification
The hardest situation to reach from the ports is an input that changes while a handshake is in progress. Examples are write data that changes under a held write strobe, or an address that moves while a read is being acknowledged. Only the final register contents or a read word that does not change can reveal whether such a change leaked through. The stimulus holds the strobe high across several peripheral cycles after the acknowledge rises, changes the data or the address inside that window, and then reads the affected registers back in later handshakes. Aliasing of out-of-window writes is caught the same way: the addresses just below and just above the window are written, and the registers they would alias onto are read back.

// File: rtl/crs_pkg.sv
// Shared types for the control-register bus slave.
// Assumes only two handshake phases are needed inside the peripheral domain.
package crs_pkg;

    typedef enum logic {
        CRS_IDLE = 1'b0,
        CRS_BUSY = 1'b1
    } crs_state_e;

endpackage

// File: rtl/crs_sync.sv
// Chain of synchronising flip-flops for a bundle of slow-domain signals.
// Assumes the source holds each value for at least two destination cycles
// (half-rate requester), so bus members settle together before use.
module crs_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= din;
                end
            end else begin : g_rest
                // Later stages re-time the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/crs_decode.sv
// Address window decode: flags a hit and yields the register index.
// Assumes BASE_ADDR + NUM_REGS fits in the address space.
module crs_decode #(
    parameter int ADDR_W    = 10,
    parameter int NUM_REGS  = 4,
    parameter int BASE_ADDR = 256,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W:0]   LO_BOUND = (ADDR_W+1)'(BASE_ADDR);
    localparam logic [ADDR_W:0]   HI_BOUND = (ADDR_W+1)'(BASE_ADDR + NUM_REGS);
    localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);

    logic [ADDR_W:0] addr_ext;

    // Window compare and offset into the bank
    always_comb begin
        addr_ext = {1'b0, addr};
        hit      = (addr_ext >= LO_BOUND) && (addr_ext < HI_BOUND);
        idx      = IDX_W'(addr - BASE_VEC);
    end

endmodule

// File: rtl/crs_regfile.sv
// Bank of data registers with one write port and one read port.
// Assumes the write enable is a single-cycle pulse per access.
module crs_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);

    logic [DATA_W-1:0] bank_q [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            // One storage word, loaded when selected by a write pulse
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[r] <= '0;
                else if (wr_en && (idx == IDX_W'(r)))
                    bank_q[r] <= wdata;
            end
        end
    endgenerate

    // Read mux over the bank
    always_comb begin
        rd_val = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (idx == IDX_W'(r)) rd_val = bank_q[r];
        end
    end

endmodule

// File: rtl/crs_ack_fsm.sv
// Four-phase acknowledge controller.
// Accepts one single-strobe, in-window request from idle, raises a
// registered acknowledge, and drops it once the starting strobe falls.
// Assumes strobes are already synchronised to clk.
module crs_ack_fsm
    import crs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic hit,
    output logic wr_en,
    output logic rd_load,
    output logic ack_drop,
    output logic op_wr,
    output logic ack
);

    crs_state_e state_q;
    logic       accept;
    logic       own_strobe;

    // Accept and release conditions
    always_comb begin
        accept     = (state_q == CRS_IDLE) && (rd_s ^ wr_s) && hit;
        own_strobe = op_wr ? wr_s : rd_s;
        ack_drop   = (state_q == CRS_BUSY) && !own_strobe;
        wr_en      = accept && wr_s;
        rd_load    = accept && rd_s;
    end

    // Handshake state, remembered operation and acknowledge flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CRS_IDLE;
            op_wr   <= 1'b0;
            ack     <= 1'b0;
        end else if (accept) begin
            state_q <= CRS_BUSY;
            op_wr   <= wr_s;
            ack     <= 1'b1;
        end else if (ack_drop) begin
            state_q <= CRS_IDLE;
            ack     <= 1'b0;
        end
    end

endmodule

// File: rtl/ctrl_reg_slave.sv
// Control-register bus slave, top level.
// Synchronises requester inputs, decodes the window, performs the access
// and answers with a registered four-phase acknowledge plus read word.
// Assumes the requester clock runs at half the rate of clk.
module ctrl_reg_slave #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int NUM_REGS    = 4,
    parameter int BASE_ADDR   = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int BUS_W  = 2 + ADDR_W + DATA_W;

    logic              rd_s;
    logic              wr_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic              rd_load;
    logic              ack_drop;
    logic              op_wr;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    crs_sync #(
        .WIDTH  (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({req_rd, req_wr, req_addr, req_wdata}),
        .dout  ({rd_s, wr_s, addr_s, wdata_s})
    );

    crs_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_REGS  (NUM_REGS),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (addr_s),
        .hit  (hit),
        .idx  (idx)
    );

    crs_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_regfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (idx),
        .wdata  (wdata_s),
        .rd_val (rd_val)
    );

    crs_ack_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_s     (rd_s),
        .wr_s     (wr_s),
        .hit      (hit),
        .wr_en    (wr_en),
        .rd_load  (rd_load),
        .ack_drop (ack_drop),
        .op_wr    (op_wr),
        .ack      (rsp_ack)
    );

    // Read-return register: loaded with the acknowledge, cleared as it falls
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (rd_load)  rdata_q <= rd_val;
        else if (ack_drop) rdata_q <= '0;
    end

    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/crs_checker.sv
// Protocol checker for the control-register bus slave, bound to the top.
module crs_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_s,
    input logic              wr_s,
    input logic              hit,
    input logic              op_wr,
    input logic              wr_en,
    input logic              rsp_ack,
    input logic [DATA_W-1:0] rsp_rdata
);

    // R1: reset leaves acknowledge and read data cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_ack && (rsp_rdata == '0)));

    // R2: acknowledge only rises after a synchronised single strobe in window
    assert_ack_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_ack) |-> ($past(rd_s ^ wr_s) && $past(hit)));

    // R4: a write pulse never lasts two cycles
    assert_write_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: read data holds while acknowledge stays high
    assert_rdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ack && $past(rsp_ack)) |-> $stable(rsp_rdata));

    // R5: read data is zero whenever acknowledge is low
    assert_rdata_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ack |-> (rsp_rdata == '0));

    // R6: acknowledge held while the starting strobe is held
    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ack && (op_wr ? wr_s : rd_s)) |=> rsp_ack);

    // R8: both strobes high from idle never yields an acknowledge
    assert_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s && wr_s && !rsp_ack) |=> !rsp_ack);

    // R7: an out-of-window address never starts an access
    assert_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !rsp_ack) |=> (!rsp_ack && !$past(wr_en)));

endmodule

bind ctrl_reg_slave crs_checker #(
    .DATA_W (DATA_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_s      (rd_s),
    .wr_s      (wr_s),
    .hit       (hit),
    .op_wr     (op_wr),
    .wr_en     (wr_en),
    .rsp_ack   (rsp_ack),
    .rsp_rdata (rsp_rdata)
);

// File: tb/tb_ctrl_reg_slave.sv
module tb_ctrl_reg_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0;
    logic        req_wr = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ack;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ctrl_reg_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata)
    );

    // Vector: {is_wr, addr[9:0], wdata[31:0], exp_ack, exp_rdata[31:0]}
    localparam int NVEC = 12;
    localparam logic [75:0] VEC [NVEC] = '{
        {1'b1, 10'h100, 32'hA5A5_0001, 1'b1, 32'h0},
        {1'b1, 10'h103, 32'hDEAD_BEEF, 1'b1, 32'h0},
        {1'b0, 10'h100, 32'h0,         1'b1, 32'hA5A5_0001},
        {1'b0, 10'h103, 32'h0,         1'b1, 32'hDEAD_BEEF},
        {1'b0, 10'h101, 32'h0,         1'b1, 32'h0},
        {1'b1, 10'h0FF, 32'h1111_1111, 1'b0, 32'h0},
        {1'b1, 10'h104, 32'h2222_2222, 1'b0, 32'h0},
        {1'b0, 10'h104, 32'h0,         1'b0, 32'h0},
        {1'b1, 10'h102, 32'h1234_5678, 1'b1, 32'h0},
        {1'b0, 10'h102, 32'h0,         1'b1, 32'h1234_5678},
        {1'b0, 10'h100, 32'h0,         1'b1, 32'hA5A5_0001},
        {1'b0, 10'h103, 32'h0,         1'b1, 32'hDEAD_BEEF}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    // One complete handshake with checks on rise, hold and fall timing
    task automatic txn(input bit is_wr, input logic [9:0] addr, input logic [31:0] data,
                       input bit exp_ack, input logic [31:0] exp_rd);
        @(negedge clk);
        req_addr  = addr;
        req_wdata = data;
        req_rd    = !is_wr;
        req_wr    = is_wr;
        repeat (2) @(negedge clk);
        chk(!rsp_ack, "R2 ack early", {31'b0, rsp_ack}, 32'h0);
        @(negedge clk);
        if (exp_ack) begin
            chk(rsp_ack, "R2 ack on third edge", {31'b0, rsp_ack}, 32'h1);
            if (!is_wr) chk(rsp_rdata == exp_rd, "R5 read data", rsp_rdata, exp_rd);
            repeat (2) @(negedge clk);
            chk(rsp_ack, "R6 ack held", {31'b0, rsp_ack}, 32'h1);
        end else begin
            repeat (3) @(negedge clk);
            chk(!rsp_ack, "R7 miss no ack", {31'b0, rsp_ack}, 32'h0);
            chk(rsp_rdata == 32'h0, "R7 miss rdata", rsp_rdata, 32'h0);
        end
        req_rd = 1'b0;
        req_wr = 1'b0;
        repeat (2) @(negedge clk);
        if (exp_ack) chk(rsp_ack, "R6 ack before fall", {31'b0, rsp_ack}, 32'h1);
        @(negedge clk);
        chk(!rsp_ack, "R6 ack falls", {31'b0, rsp_ack}, 32'h0);
        chk(rsp_rdata == 32'h0, "R5 rdata zero after ack", rsp_rdata, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!rsp_ack, "R1 reset ack", {31'b0, rsp_ack}, 32'h0);
        chk(rsp_rdata == 32'h0, "R1 reset rdata", rsp_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: writes, reads, window edges (R3, R4, R5, R7)
        for (int i = 0; i < NVEC; i++) begin
            txn(VEC[i][75], VEC[i][74:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0]);
        end

        // R4: data changed under a held write strobe is not stored
        @(negedge clk);
        req_addr = 10'h101; req_wdata = 32'h0000_AAAA; req_wr = 1'b1;
        repeat (3) @(negedge clk);
        chk(rsp_ack, "R4 write ack", {31'b0, rsp_ack}, 32'h1);
        req_wdata = 32'h0000_5555;
        repeat (4) @(negedge clk);
        req_wr = 1'b0;
        repeat (4) @(negedge clk);
        txn(1'b0, 10'h101, 32'h0, 1'b1, 32'h0000_AAAA);

        // R8: both strobes together give no ack and no write
        @(negedge clk);
        req_addr = 10'h102; req_wdata = 32'hFFFF_FFFF; req_rd = 1'b1; req_wr = 1'b1;
        repeat (6) @(negedge clk);
        chk(!rsp_ack, "R8 conflict no ack", {31'b0, rsp_ack}, 32'h0);
        chk(rsp_rdata == 32'h0, "R8 conflict rdata", rsp_rdata, 32'h0);
        req_rd = 1'b0; req_wr = 1'b0;
        repeat (4) @(negedge clk);
        txn(1'b0, 10'h102, 32'h0, 1'b1, 32'h1234_5678);

        // R9: address change during an acknowledged read has no effect
        @(negedge clk);
        req_addr = 10'h100; req_rd = 1'b1;
        repeat (3) @(negedge clk);
        chk(rsp_rdata == 32'hA5A5_0001, "R9 read before change", rsp_rdata, 32'hA5A5_0001);
        req_addr = 10'h103;
        repeat (4) @(negedge clk);
        chk(rsp_ack, "R9 ack kept", {31'b0, rsp_ack}, 32'h1);
        chk(rsp_rdata == 32'hA5A5_0001, "R9 rdata unchanged", rsp_rdata, 32'hA5A5_0001);
        req_rd = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset mid-run clears the bank
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!rsp_ack, "R1 reset ack again", {31'b0, rsp_ack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        txn(1'b0, 10'h103, 32'h0, 1'b1, 32'h0);
        txn(1'b0, 10'h100, 32'h0, 1'b1, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule